// File: doc/BRIEF.md
# Nonvolatile Store/Recall Power Controller

This block sequences copies between a volatile memory array and its nonvolatile shadow. It watches two supply comparator flags, one for the switch threshold and one for the deeper reset threshold. It also takes one-cycle software requests for a save or a restore, which a separate command decoder produces. It keeps a flag that records whether the array was written since the last completed operation. When the supply drops and that flag is set, it starts a save at once. When the supply returns after a deep drop, it starts a restore.

A save is an erase phase followed by a program phase. A restore is a clear phase followed by a transfer phase. Each phase lasts half of its operation's total time, and the cycle counts come from a clock-rate parameter and per-operation durations in microseconds. While an operation runs, `busy` is high and the array's write permission is withdrawn. Requests that arrive during an operation are dropped. All pins are plain level or pulse control signals. The block has no data path, so it has no valid/ready interface.

Top module: `nvsr_power_ctrl`

## Requirements
- R1: A pulse on `arr_wr` in a cycle where `wr_allow` is high sets the internal dirty flag. Completing any save or restore clears the flag. The flag is 0 after reset.
- R2: When `vlow_sw` is sampled high while idle, a save starts only if the dirty flag is set. Otherwise nothing starts.
- R3: A software save request, sampled while idle and with `vlow_sw` low, is latched. The save starts on the next clock edge whether or not the dirty flag is set.
- R4: Reset and any cycle with `vlow_rst` high arm a pending restore. It starts, with power-up duration, at the first idle edge where `vlow_sw` is low.
- R5: A drop with `vlow_sw` high but `vlow_rst` never high arms no restore, so none runs when the supply returns.
- R6: While `vlow_sw` is high, `wr_allow` is low and software requests are dropped, including any already latched.
- R7: A save drives `erase_ph` for ST_CYC/2 cycles, then `program_ph` for ST_CYC/2 cycles, where ST_CYC = STORE_US*CLK_MHZ.
- R8: A restore drives `clear_ph` and then `transfer_ph`, each for half its total. The total is SWRCL_US*CLK_MHZ cycles for a software restore and PWRCL_US*CLK_MHZ cycles for a power-up restore.
- R9: `busy` is high exactly while a phase strobe is high. `wr_allow` is low while busy. Writes and software requests during busy have no effect.
- R10: An automatic save shows `erase_ph` high in the cycle right after the edge that sampled `vlow_sw` high.
- R11: Start priority when idle: the automatic save while below the switch level, then the pending power-up restore, then a latched software save, then a latched software restore. A software request latched in the same edge that starts another operation is served after that operation completes.
- R12: During reset, `busy` and all four phase strobes are low.
- R13: At most one phase strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vlow_sw | input | 1 | Supply below switch threshold |
| vlow_rst | input | 1 | Supply below reset threshold |
| arr_wr | input | 1 | Array write attempt, one per cycle |
| sw_store_req | input | 1 | Software save request pulse |
| sw_recall_req | input | 1 | Software restore request pulse |
| wr_allow | output | 1 | Array writes permitted this cycle |
| busy | output | 1 | Operation in progress, external access blocked |
| erase_ph | output | 1 | Save, erase phase |
| program_ph | output | 1 | Save, program phase |
| clear_ph | output | 1 | Restore, clear phase |
| transfer_ph | output | 1 | Restore, transfer phase |

## Verification
The properties assume that `vlow_rst` is only ever high together with `vlow_sw`, since the reset threshold lies below the switch threshold. They also assume that each operation runs to its end, so a falling erase or clear strobe is always followed by the next phase. The stimulus raises `vlow_rst` only inside windows where `vlow_sw` is already high, and it clears both together. Every phase is at least one cycle long because the bench durations are set to small even cycle counts.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_STORE = 2'd1,
    OP_SWRCL = 2'd2,
    OP_PWRCL = 2'd3
  } op_e;
endpackage

// File: rtl/nvsr_dirty.sv
module nvsr_dirty (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  input  logic wr_ok,
  input  logic op_done,
  output logic dirty
);
  always_ff @(posedge clk) begin
    if (!rst_n)               dirty <= 1'b0;
    else if (op_done)         dirty <= 1'b0;
    else if (wr_req && wr_ok) dirty <= 1'b1;
  end
endmodule

// File: rtl/nvsr_arb.sv
module nvsr_arb
  import nvsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vlow_sw,
  input  logic vlow_rst,
  input  logic sw_store_req,
  input  logic sw_recall_req,
  input  logic idle,
  input  logic dirty,
  output logic start,
  output op_e  start_op
);
  logic pend_pwr, pend_st, pend_rc;

  always_comb begin
    start    = 1'b0;
    start_op = OP_IDLE;
    if (idle) begin
      if (vlow_sw) begin
        if (dirty) begin
          start    = 1'b1;
          start_op = OP_STORE;
        end
      end else if (pend_pwr) begin
        start    = 1'b1;
        start_op = OP_PWRCL;
      end else if (pend_st) begin
        start    = 1'b1;
        start_op = OP_STORE;
      end else if (pend_rc) begin
        start    = 1'b1;
        start_op = OP_SWRCL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_pwr <= 1'b1;
      pend_st  <= 1'b0;
      pend_rc  <= 1'b0;
    end else begin
      if (vlow_rst)                            pend_pwr <= 1'b1;
      else if (start && start_op == OP_PWRCL)  pend_pwr <= 1'b0;

      if (vlow_sw)                             pend_st <= 1'b0;
      else if (start && start_op == OP_STORE)  pend_st <= 1'b0;
      else if (sw_store_req && idle)           pend_st <= 1'b1;

      if (vlow_sw)                             pend_rc <= 1'b0;
      else if (start && start_op == OP_SWRCL)  pend_rc <= 1'b0;
      else if (sw_recall_req && idle)          pend_rc <= 1'b1;
    end
  end
endmodule

// File: rtl/nvsr_seq.sv
module nvsr_seq
  import nvsr_pkg::*;
#(
  parameter int ST_HALF = 250000,
  parameter int SR_HALF = 500,
  parameter int PR_HALF = 13750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  op_e  start_op,
  output op_e  op,
  output logic second,
  output logic done
);
  localparam int MAXH = (ST_HALF > SR_HALF) ?
                        ((ST_HALF > PR_HALF) ? ST_HALF : PR_HALF) :
                        ((SR_HALF > PR_HALF) ? SR_HALF : PR_HALF);
  localparam int CW = $clog2(MAXH + 1);

  logic [CW-1:0] cnt, half_m1;

  always_comb begin
    case (op)
      OP_STORE: half_m1 = CW'(ST_HALF - 1);
      OP_SWRCL: half_m1 = CW'(SR_HALF - 1);
      OP_PWRCL: half_m1 = CW'(PR_HALF - 1);
      default:  half_m1 = '0;
    endcase
  end

  assign done = (op != OP_IDLE) && second && (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op     <= OP_IDLE;
      second <= 1'b0;
      cnt    <= '0;
    end else if (op == OP_IDLE) begin
      if (start) begin
        op     <= start_op;
        second <= 1'b0;
        cnt    <= '0;
      end
    end else if (cnt == half_m1) begin
      cnt <= '0;
      if (second) begin
        op     <= OP_IDLE;
        second <= 1'b0;
      end else begin
        second <= 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/nvsr_power_ctrl.sv
module nvsr_power_ctrl
  import nvsr_pkg::*;
#(
  parameter int CLK_MHZ  = 50,
  parameter int STORE_US = 10000,
  parameter int SWRCL_US = 20,
  parameter int PWRCL_US = 550
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vlow_sw,
  input  logic vlow_rst,
  input  logic arr_wr,
  input  logic sw_store_req,
  input  logic sw_recall_req,
  output logic wr_allow,
  output logic busy,
  output logic erase_ph,
  output logic program_ph,
  output logic clear_ph,
  output logic transfer_ph
);
  localparam int ST_HALF = (STORE_US * CLK_MHZ) / 2;
  localparam int SR_HALF = (SWRCL_US * CLK_MHZ) / 2;
  localparam int PR_HALF = (PWRCL_US * CLK_MHZ) / 2;

  logic dirty, start, second, done;
  op_e  start_op, op;

  assign busy     = (op != OP_IDLE);
  assign wr_allow = !busy && !vlow_sw;

  nvsr_dirty u_dirty (
    .clk(clk), .rst_n(rst_n), .wr_req(arr_wr), .wr_ok(wr_allow),
    .op_done(done), .dirty(dirty)
  );

  nvsr_arb u_arb (
    .clk(clk), .rst_n(rst_n), .vlow_sw(vlow_sw), .vlow_rst(vlow_rst),
    .sw_store_req(sw_store_req), .sw_recall_req(sw_recall_req),
    .idle(!busy), .dirty(dirty), .start(start), .start_op(start_op)
  );

  nvsr_seq #(.ST_HALF(ST_HALF), .SR_HALF(SR_HALF), .PR_HALF(PR_HALF)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
    .op(op), .second(second), .done(done)
  );

  assign erase_ph    = (op == OP_STORE) && !second;
  assign program_ph  = (op == OP_STORE) && second;
  assign clear_ph    = ((op == OP_SWRCL) || (op == OP_PWRCL)) && !second;
  assign transfer_ph = ((op == OP_SWRCL) || (op == OP_PWRCL)) && second;
endmodule

// File: rtl/nvsr_power_ctrl_chk.sv
module nvsr_power_ctrl_chk #(
  parameter int ST_HALF = 2
) (
  input logic clk,
  input logic rst_n,
  input logic vlow_sw,
  input logic wr_allow,
  input logic busy,
  input logic erase_ph,
  input logic program_ph,
  input logic clear_ph,
  input logic transfer_ph
);
  int unsigned ecnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        ecnt <= 0;
    else if (erase_ph) ecnt <= ecnt + 1;
    else               ecnt <= 0;
  end

  p_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_ph, program_ph, clear_ph, transfer_ph}));

  p_busy_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (erase_ph || program_ph || clear_ph || transfer_ph));

  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_allow);

  p_low_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vlow_sw |-> !wr_allow);

  p_erase_to_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_ph) |-> program_ph);

  p_erase_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_ph) |-> (ecnt == ST_HALF));

  p_clear_to_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clear_ph) |-> transfer_ph);

  p_no_low_recall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && vlow_sw) |=> !clear_ph);
endmodule

bind nvsr_power_ctrl nvsr_power_ctrl_chk #(.ST_HALF(ST_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .vlow_sw(vlow_sw), .wr_allow(wr_allow),
  .busy(busy), .erase_ph(erase_ph), .program_ph(program_ph),
  .clear_ph(clear_ph), .transfer_ph(transfer_ph)
);

// File: tb/nvsr_power_ctrl_test.sv
`timescale 1ns/1ps
module nvsr_power_ctrl_test;
  localparam int CLK_MHZ = 1, STORE_US = 40, SWRCL_US = 4, PWRCL_US = 8;
  localparam int T_ST = STORE_US * CLK_MHZ;
  localparam int T_SR = SWRCL_US * CLK_MHZ;
  localparam int T_PR = PWRCL_US * CLK_MHZ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vlow_sw = 1'b1, vlow_rst = 1'b1, arr_wr = 1'b0;
  logic sw_store_req = 1'b0, sw_recall_req = 1'b0;
  logic wr_allow, busy, erase_ph, program_ph, clear_ph, transfer_ph;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nvsr_power_ctrl #(.CLK_MHZ(CLK_MHZ), .STORE_US(STORE_US),
                    .SWRCL_US(SWRCL_US), .PWRCL_US(PWRCL_US)) uut (
    .clk(clk), .rst_n(rst_n), .vlow_sw(vlow_sw), .vlow_rst(vlow_rst),
    .arr_wr(arr_wr), .sw_store_req(sw_store_req), .sw_recall_req(sw_recall_req),
    .wr_allow(wr_allow), .busy(busy), .erase_ph(erase_ph),
    .program_ph(program_ph), .clear_ph(clear_ph), .transfer_ph(transfer_ph)
  );

  // Behavioural reference: 0 idle, 1 save, 2 sw restore, 3 power-up restore
  int m_op = 0, m_cnt = 0;
  bit m_dirty = 0, m_pend = 1, m_ps = 0, m_pr = 0;

  function automatic int tot(int op);
    return (op == 1) ? T_ST : (op == 2) ? T_SR : T_PR;
  endfunction

  always @(posedge clk) begin
    bit idle, wa, done;
    int nop;
    idle = (m_op == 0);
    wa = idle && !vlow_sw;
    done = 0;
    nop = 0;
    if (!rst_n) begin
      m_op = 0; m_cnt = 0; m_dirty = 0; m_pend = 1; m_ps = 0; m_pr = 0;
    end else begin
      if (!idle) begin
        if (m_cnt == tot(m_op) - 1) begin m_op = 0; m_cnt = 0; done = 1; end
        else m_cnt++;
      end else begin
        if (vlow_sw) begin if (m_dirty) nop = 1; end
        else if (m_pend) nop = 3;
        else if (m_ps) nop = 1;
        else if (m_pr) nop = 2;
        if (nop != 0) begin m_op = nop; m_cnt = 0; end
      end
      if (done) m_dirty = 0;
      else if (arr_wr && wa) m_dirty = 1;
      if (vlow_rst) m_pend = 1;
      else if (nop == 3) m_pend = 0;
      if (vlow_sw) m_ps = 0;
      else if (nop == 1) m_ps = 0;
      else if (sw_store_req && idle) m_ps = 1;
      if (vlow_sw) m_pr = 0;
      else if (nop == 2) m_pr = 0;
      else if (sw_recall_req && idle) m_pr = 1;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int h;
      h = tot(m_op) / 2;
      chk(busy == (m_op != 0), "R9 busy", busy, m_op != 0);
      chk(erase_ph == (m_op == 1 && m_cnt < h), "R7 erase", erase_ph, m_op == 1 && m_cnt < h);
      chk(program_ph == (m_op == 1 && m_cnt >= h), "R7 program", program_ph, m_op == 1 && m_cnt >= h);
      chk(clear_ph == (m_op >= 2 && m_cnt < h), "R8 clear", clear_ph, m_op >= 2 && m_cnt < h);
      chk(transfer_ph == (m_op >= 2 && m_cnt >= h), "R8 transfer", transfer_ph, m_op >= 2 && m_cnt >= h);
      chk(wr_allow == (m_op == 0 && !vlow_sw), "R6 wr_allow", wr_allow, m_op == 0 && !vlow_sw);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 1000) begin g++; tick(); end
  endtask

  initial begin
    #(20 * 200000);
    chk(0, "watchdog", 0, 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    tick(3);
    chk(!busy && !erase_ph && !program_ph && !clear_ph && !transfer_ph, "R12 reset", busy, 0);
    rst_n = 1'b1; vlow_rst = 1'b0;           // supply between thresholds
    tick(3);
    chk(!busy, "R4 waits for switch level", busy, 0);
    vlow_sw = 1'b0;
    tick();
    chk(clear_ph, "R4 power-up restore starts", clear_ph, 1);
    n = 1; tick();
    while (clear_ph || transfer_ph) begin n++; tick(); end
    chk(n == T_PR, "R8 power-up restore length", n, T_PR);

    vlow_sw = 1'b1;                            // clean drop
    tick(4);
    chk(!busy, "R2 no save when clean", busy, 0);
    vlow_sw = 1'b0; tick();

    arr_wr = 1'b1; tick(); arr_wr = 1'b0;     // dirty, then drop
    vlow_sw = 1'b1; tick();
    chk(erase_ph, "R10 R2 auto save next cycle", erase_ph, 1);
    wait_idle();
    vlow_sw = 1'b0; tick(3);
    chk(!busy, "R5 brown-out gives no restore", busy, 0);
    vlow_sw = 1'b1; tick(3);
    chk(!busy, "R1 flag cleared by save", busy, 0);
    vlow_sw = 1'b0; tick();

    sw_store_req = 1'b1; tick(); sw_store_req = 1'b0;
    tick();
    chk(erase_ph, "R3 sw save while clean", erase_ph, 1);
    sw_recall_req = 1'b1; arr_wr = 1'b1; tick();
    sw_recall_req = 1'b0; arr_wr = 1'b0;
    n = 1;
    while (erase_ph) begin n++; tick(); end
    chk(n == T_ST / 2, "R7 erase length", n, T_ST / 2);
    n = 0;
    while (program_ph) begin n++; tick(); end
    chk(n == T_ST / 2, "R7 program length", n, T_ST / 2);
    tick(3);
    chk(!busy, "R9 request during busy dropped", busy, 0);
    vlow_sw = 1'b1; tick(3);
    chk(!busy, "R9 write during busy dropped", busy, 0);
    vlow_sw = 1'b0; tick();

    sw_recall_req = 1'b1; tick(); sw_recall_req = 1'b0;
    tick();
    chk(clear_ph, "R8 sw restore starts", clear_ph, 1);
    n = 1; tick();
    while (clear_ph || transfer_ph) begin n++; tick(); end
    chk(n == T_SR, "R8 sw restore length", n, T_SR);

    vlow_sw = 1'b1; tick();
    chk(!wr_allow, "R6 writes blocked when low", wr_allow, 0);
    sw_store_req = 1'b1; arr_wr = 1'b1; tick();
    sw_store_req = 1'b0; arr_wr = 1'b0; tick();
    vlow_sw = 1'b0; tick(4);
    chk(!busy, "R6 request while low dropped", busy, 0);

    vlow_sw = 1'b1; vlow_rst = 1'b1; tick(2);
    vlow_sw = 1'b0; vlow_rst = 1'b0; sw_store_req = 1'b1; tick();
    sw_store_req = 1'b0;
    chk(clear_ph, "R11 power-up restore first", clear_ph, 1);
    wait_idle();
    tick();
    chk(erase_ph, "R11 sw save served after", erase_ph, 1);
    wait_idle();
    tick(2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule